// File: doc/BRIEF.md
# Raster LCD Panel Timing Generator

This block drives the raster timing of a parallel RGB panel. From one system clock it derives a pixel-clock enable, then walks a horizontal and a vertical position counter through four phases: sync pulse, back porch, active area and front porch. From these positions it produces horizontal sync, vertical sync and data-enable. It also presents the column and row of the current active pixel and a one-clock frame-start strobe, which a downstream pixel source uses to stay aligned.

Configuration arrives on plain input fields, and the encoding differs from field to field. The horizontal sync, back porch and front porch fields and both active-size fields hold their count minus one. The vertical sync width field also holds its count minus one. The vertical back and front porch fields hold raw line counts, so either may be zero. The pixel enable divides the system clock by twice the divider field plus one, unless the bypass bit is set. The configuration is captured while the core is idle and at each frame boundary, so a change made mid-frame never splits a frame.

A power input starts the raster. When power is withdrawn, the core completes the frame in progress before it drops its busy flag and parks every output at its inactive level. Software may rewrite the configuration only after busy has fallen.

Top module: `lcd_raster_timer`

## Requirements
- R1: With `cfg_bypass` low and the core busy, `pix_ce` is high for one clock in every 2*(`cfg_clkdiv`+1) clocks. The first pulse comes 2*(`cfg_clkdiv`+1) clocks after the edge that raised `busy`.
- R2: With `cfg_bypass` high and the core busy, `pix_ce` is high on every clock.
- R3: A line lasts (`cfg_hpw`+1)+(`cfg_hbp`+1)+(`cfg_hact`+1)+(`cfg_hfp`+1) pixel periods, in the order sync, back porch, active, front porch. The horizontal sync pulse covers the first `cfg_hpw`+1 periods of the line.
- R4: A frame lasts (`cfg_vpw`+1)+`cfg_vbp`+(`cfg_vact`+1)+`cfg_vfp` lines, in the same phase order. Vertical sync covers the first `cfg_vpw`+1 lines. A back or front porch of zero lines is allowed.
- R5: `hsync` equals the horizontal sync phase XOR `cfg_hs_inv`, and `vsync` equals the vertical sync phase XOR `cfg_vs_inv`. A value of 0 means active-high.
- R6: `de` is high only where both axes are in their active phase. `px_x` and `px_y` then give the column and row within the active area, counted from 0. Both are 0 whenever `de` is low.
- R7: `frame_start` is high for exactly one clock per frame: the clock of the first active pixel (column 0, row 0) on which `pix_ce` is high.
- R8: While idle, a high `pwr_en` raises `busy` at the next edge, and the raster starts at line 0, pixel 0. When `pwr_en` is low at the last pixel period of a frame, `busy` falls at the end of that period. While `busy` is low, `pix_ce`, `de`, `frame_start`, `px_x` and `px_y` are 0, and each sync output sits at its inversion bit's level.
- R9: The configuration is captured on every clock while idle and on the closing pixel period of each frame. A change made at any other time has no effect until the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Run request |
| cfg_bypass | input | 1 | Pixel enable on every clock |
| cfg_clkdiv | input | DIV_W | Divider N, period 2*(N+1) clocks |
| cfg_hs_inv | input | 1 | Invert horizontal sync |
| cfg_vs_inv | input | 1 | Invert vertical sync |
| cfg_hpw | input | HP_W | Horizontal sync width minus one |
| cfg_hbp | input | HP_W | Horizontal back porch minus one |
| cfg_hfp | input | HP_W | Horizontal front porch minus one |
| cfg_hact | input | ACT_W | Active columns minus one |
| cfg_vpw | input | VPW_W | Vertical sync lines minus one |
| cfg_vbp | input | VP_W | Vertical back porch lines, raw |
| cfg_vfp | input | VP_W | Vertical front porch lines, raw |
| cfg_vact | input | ACT_W | Active rows minus one |
| pix_ce | output | 1 | Pixel clock enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| px_x | output | ACT_W | Active column |
| px_y | output | ACT_W | Active row |
| frame_start | output | 1 | First active pixel strobe |
| busy | output | 1 | Core running |

## Verification
A wrong divider count shows up as a `pix_ce` pulse on the wrong clock within the first pixel period. A position counter that slips shifts `hsync`, `de` and `px_x` on the very next pixel period and carries the error into every later line. A configuration register that loads mid-frame moves the active window or flips a sync level before the frame has ended. A stop state machine that leaves early or late moves the falling edge of `busy` away from the frame's final pixel period. The bench runs a behavioural model of the raster beside the design and compares every output on every clock, so each of these faults surfaces in the cycle where it first appears.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;

   typedef enum logic {
      RST_IDLE   = 1'b0,
      RST_ACTIVE = 1'b1
   } raster_state_e;

   // pick the larger of two widths
   function automatic int wmax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lcd_pixclk_gen.sv
module lcd_pixclk_gen #(
   parameter int DIV_W     = 8,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             bypass,
   input  logic [DIV_W-1:0] div,
   output logic             ce
);
   localparam int CNT_W = DIV_W + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last_cnt;
   logic             byp_eff;

   initial begin : param_chk
      assert (DIV_W >= 1) else $error("lcd_pixclk_gen: DIV_W must be at least 1");
   end

   generate
      if (BYPASS_EN) begin : g_byp
         assign byp_eff = bypass;
      end else begin : g_nobyp
         assign byp_eff = 1'b0;
      end
   endgenerate

   // period of 2*(div+1) clocks ends at count 2*div+1
   assign last_cnt = {div, 1'b1};
   assign ce       = run && (byp_eff || (cnt == last_cnt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || byp_eff || (cnt == last_cnt))
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   // R1
   ce_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !byp_eff) |=> (!ce || byp_eff))
      else $error("pixel enable on consecutive clocks while dividing");

   // R2
   ce_byp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && byp_eff) |-> ce)
      else $error("bypass did not give a pixel enable");

endmodule

// File: rtl/lcd_axis_ctr.sv
module lcd_axis_ctr #(
   parameter int CW    = 13,
   parameter int IDX_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step,
   input  logic [CW-1:0]    sync_len,
   input  logic [CW-1:0]    back_len,
   input  logic [CW-1:0]    act_len,
   input  logic [CW-1:0]    front_len,
   output logic             at_last,
   output logic             in_sync,
   output logic             in_act,
   output logic             at_first_act,
   output logic [IDX_W-1:0] act_idx
);
   logic [CW-1:0] pos;
   logic [CW-1:0] total;
   logic [CW-1:0] act_lo;
   logic [CW-1:0] act_hi;

   initial begin : param_chk
      assert (CW > IDX_W) else $error("lcd_axis_ctr: CW must exceed IDX_W");
   end

   assign act_lo       = sync_len + back_len;
   assign act_hi       = act_lo + act_len;
   assign total        = act_hi + front_len;
   assign at_last      = (pos == total - 1'b1);
   assign in_sync      = (pos < sync_len);
   assign in_act       = (pos >= act_lo) && (pos < act_hi);
   assign at_first_act = (pos == act_lo);
   assign act_idx      = in_act ? IDX_W'(pos - act_lo) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pos <= '0;
      else if (!run)
         pos <= '0;
      else if (step)
         pos <= at_last ? '0 : pos + 1'b1;
   end

   // R3
   pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (pos < total))
      else $error("axis position beyond its period");

endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
   import lcd_raster_pkg::*;
#(
   parameter int DIV_W     = 8,
   parameter int HP_W      = 8,
   parameter int VPW_W     = 6,
   parameter int VP_W      = 8,
   parameter int ACT_W     = 11,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_en,
   input  logic             cfg_bypass,
   input  logic [DIV_W-1:0] cfg_clkdiv,
   input  logic             cfg_hs_inv,
   input  logic             cfg_vs_inv,
   input  logic [HP_W-1:0]  cfg_hpw,
   input  logic [HP_W-1:0]  cfg_hbp,
   input  logic [HP_W-1:0]  cfg_hfp,
   input  logic [ACT_W-1:0] cfg_hact,
   input  logic [VPW_W-1:0] cfg_vpw,
   input  logic [VP_W-1:0]  cfg_vbp,
   input  logic [VP_W-1:0]  cfg_vfp,
   input  logic [ACT_W-1:0] cfg_vact,
   output logic             pix_ce,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic [ACT_W-1:0] px_x,
   output logic [ACT_W-1:0] px_y,
   output logic             frame_start,
   output logic             busy
);
   localparam int PW_MAX = wmax(HP_W, wmax(VPW_W, VP_W));
   localparam int CW     = wmax(ACT_W, PW_MAX) + 2;

   initial begin : param_chk
      assert (ACT_W >= 2) else $error("lcd_raster_timer: ACT_W too small");
      assert (HP_W >= 1 && VPW_W >= 1 && VP_W >= 1)
         else $error("lcd_raster_timer: porch widths must be positive");
   end

   raster_state_e    state;
   logic             run;
   logic             cfg_load;
   logic             frame_wrap;
   logic             v_step;

   logic             byp_q, hs_inv_q, vs_inv_q;
   logic [DIV_W-1:0] div_q;
   logic [HP_W-1:0]  hpw_q, hbp_q, hfp_q;
   logic [VPW_W-1:0] vpw_q;
   logic [VP_W-1:0]  vbp_q, vfp_q;
   logic [ACT_W-1:0] hact_q, vact_q;

   logic [CW-1:0]    h_s, h_b, h_a, h_f;
   logic [CW-1:0]    v_s, v_b, v_a, v_f;

   logic             h_last, h_sync_ph, h_act, h_first;
   logic             v_last, v_sync_ph, v_act, v_first;
   logic [ACT_W-1:0] h_idx, v_idx;

   assign run        = (state == RST_ACTIVE);
   assign v_step     = pix_ce && h_last;
   assign frame_wrap = v_step && v_last;
   assign cfg_load   = !run || frame_wrap;

   // power sequencing: start at once, stop only at a frame end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= RST_IDLE;
      else begin
         case (state)
            RST_IDLE:   if (pwr_en) state <= RST_ACTIVE;
            RST_ACTIVE: if (frame_wrap && !pwr_en) state <= RST_IDLE;
            default:    state <= RST_IDLE;
         endcase
      end
   end

   // configuration shadow, loaded while idle and at frame boundaries
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byp_q    <= 1'b0;
         hs_inv_q <= 1'b0;
         vs_inv_q <= 1'b0;
         div_q    <= '0;
         hpw_q    <= '0;
         hbp_q    <= '0;
         hfp_q    <= '0;
         hact_q   <= '0;
         vpw_q    <= '0;
         vbp_q    <= '0;
         vfp_q    <= '0;
         vact_q   <= '0;
      end else if (cfg_load) begin
         byp_q    <= cfg_bypass;
         hs_inv_q <= cfg_hs_inv;
         vs_inv_q <= cfg_vs_inv;
         div_q    <= cfg_clkdiv;
         hpw_q    <= cfg_hpw;
         hbp_q    <= cfg_hbp;
         hfp_q    <= cfg_hfp;
         hact_q   <= cfg_hact;
         vpw_q    <= cfg_vpw;
         vbp_q    <= cfg_vbp;
         vfp_q    <= cfg_vfp;
         vact_q   <= cfg_vact;
      end
   end

   // field decoding: minus-one fields gain one, raw vertical porches pass
   assign h_s = CW'(hpw_q)  + CW'(1);
   assign h_b = CW'(hbp_q)  + CW'(1);
   assign h_a = CW'(hact_q) + CW'(1);
   assign h_f = CW'(hfp_q)  + CW'(1);
   assign v_s = CW'(vpw_q)  + CW'(1);
   assign v_b = CW'(vbp_q);
   assign v_a = CW'(vact_q) + CW'(1);
   assign v_f = CW'(vfp_q);

   lcd_pixclk_gen #(
      .DIV_W     (DIV_W),
      .BYPASS_EN (BYPASS_EN)
   ) u_pclk (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .bypass (byp_q),
      .div    (div_q),
      .ce     (pix_ce)
   );

   lcd_axis_ctr #(
      .CW    (CW),
      .IDX_W (ACT_W)
   ) u_hctr (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (run),
      .step         (pix_ce),
      .sync_len     (h_s),
      .back_len     (h_b),
      .act_len      (h_a),
      .front_len    (h_f),
      .at_last      (h_last),
      .in_sync      (h_sync_ph),
      .in_act       (h_act),
      .at_first_act (h_first),
      .act_idx      (h_idx)
   );

   lcd_axis_ctr #(
      .CW    (CW),
      .IDX_W (ACT_W)
   ) u_vctr (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (run),
      .step         (v_step),
      .sync_len     (v_s),
      .back_len     (v_b),
      .act_len      (v_a),
      .front_len    (v_f),
      .at_last      (v_last),
      .in_sync      (v_sync_ph),
      .in_act       (v_act),
      .at_first_act (v_first),
      .act_idx      (v_idx)
   );

   assign hsync       = (run && h_sync_ph) ^ hs_inv_q;
   assign vsync       = (run && v_sync_ph) ^ vs_inv_q;
   assign de          = run && h_act && v_act;
   assign px_x        = de ? h_idx : '0;
   assign px_y        = de ? v_idx : '0;
   assign frame_start = pix_ce && de && h_first && v_first;
   assign busy        = run;

   // R8
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(frame_wrap) && !$past(pwr_en)))
      else $error("busy fell away from a frame end");

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!de && !pix_ce && !frame_start && px_x == '0 && px_y == '0))
      else $error("activity while idle");

   // R6
   de_blank_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (hsync == hs_inv_q && vsync == vs_inv_q))
      else $error("data enable during a sync pulse");

   // R7
   fs_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (de && pix_ce && px_x == '0 && px_y == '0))
      else $error("frame start away from the first active pixel");

   // R9
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !frame_wrap) |=> ($stable(hact_q) && $stable(div_q) && $stable(hs_inv_q)))
      else $error("configuration changed mid-frame");

endmodule

// File: tb/sim_lcd_raster_timer.sv
module sim_lcd_raster_timer;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG       = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_en = 1'b0;
   logic        cfg_bypass = 1'b0;
   logic [7:0]  cfg_clkdiv = '0;
   logic        cfg_hs_inv = 1'b0;
   logic        cfg_vs_inv = 1'b0;
   logic [7:0]  cfg_hpw = '0, cfg_hbp = '0, cfg_hfp = '0;
   logic [10:0] cfg_hact = '0, cfg_vact = '0;
   logic [5:0]  cfg_vpw = '0;
   logic [7:0]  cfg_vbp = '0, cfg_vfp = '0;

   logic        pix_ce, hsync, vsync, de, frame_start, busy;
   logic [10:0] px_x, px_y;

   int tests = 0;
   int fails = 0;
   bit cmp_on = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lcd_raster_timer u0 (
      .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en),
      .cfg_bypass(cfg_bypass), .cfg_clkdiv(cfg_clkdiv),
      .cfg_hs_inv(cfg_hs_inv), .cfg_vs_inv(cfg_vs_inv),
      .cfg_hpw(cfg_hpw), .cfg_hbp(cfg_hbp), .cfg_hfp(cfg_hfp), .cfg_hact(cfg_hact),
      .cfg_vpw(cfg_vpw), .cfg_vbp(cfg_vbp), .cfg_vfp(cfg_vfp), .cfg_vact(cfg_vact),
      .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .de(de),
      .px_x(px_x), .px_y(px_y), .frame_start(frame_start), .busy(busy)
   );

   // behavioural raster model
   int m_run, m_div, m_h, m_v;
   int c_byp, c_div, c_hsi, c_vsi, c_hpw, c_hbp, c_hfp, c_hact, c_vpw, c_vbp, c_vfp, c_vact;

   function automatic int htot();
      return (c_hpw + 1) + (c_hbp + 1) + (c_hact + 1) + (c_hfp + 1);
   endfunction
   function automatic int vtot();
      return (c_vpw + 1) + c_vbp + (c_vact + 1) + c_vfp;
   endfunction
   function automatic int e_ce();
      return (m_run != 0 && (c_byp != 0 || m_div == 2 * c_div + 1)) ? 1 : 0;
   endfunction
   function automatic int h_on();
      return (m_h >= c_hpw + c_hbp + 2 && m_h < c_hpw + c_hbp + c_hact + 3) ? 1 : 0;
   endfunction
   function automatic int v_on();
      return (m_v >= c_vpw + 1 + c_vbp && m_v < c_vpw + c_vbp + c_vact + 2) ? 1 : 0;
   endfunction
   function automatic int e_de();
      return (m_run != 0 && h_on() != 0 && v_on() != 0) ? 1 : 0;
   endfunction

   task automatic load_cfg();
      c_byp = cfg_bypass; c_div = cfg_clkdiv; c_hsi = cfg_hs_inv; c_vsi = cfg_vs_inv;
      c_hpw = cfg_hpw; c_hbp = cfg_hbp; c_hfp = cfg_hfp; c_hact = cfg_hact;
      c_vpw = cfg_vpw; c_vbp = cfg_vbp; c_vfp = cfg_vfp; c_vact = cfg_vact;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_div = 0; m_h = 0; m_v = 0;
         c_byp = 0; c_div = 0; c_hsi = 0; c_vsi = 0; c_hpw = 0; c_hbp = 0;
         c_hfp = 0; c_hact = 0; c_vpw = 0; c_vbp = 0; c_vfp = 0; c_vact = 0;
      end else if (m_run == 0) begin
         m_div = 0; m_h = 0; m_v = 0;
         if (pwr_en) m_run = 1;
         load_cfg();
      end else begin
         automatic int ce   = e_ce();
         automatic int wrap = (ce != 0 && m_h == htot() - 1 && m_v == vtot() - 1) ? 1 : 0;
         if (c_byp != 0 || ce != 0) m_div = 0; else m_div++;
         if (ce != 0) begin
            if (m_h == htot() - 1) begin
               m_h = 0;
               m_v = (m_v == vtot() - 1) ? 0 : m_v + 1;
            end else m_h++;
         end
         if (wrap != 0) begin
            load_cfg();
            if (!pwr_en) m_run = 0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // cycle compare, away from the active edge
   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         automatic int xde = e_de();
         automatic int xce = e_ce();
         automatic int xhs = ((m_run != 0 && m_h < c_hpw + 1) ? 1 : 0) ^ c_hsi;
         automatic int xvs = ((m_run != 0 && m_v < c_vpw + 1) ? 1 : 0) ^ c_vsi;
         automatic int xx  = (xde != 0) ? m_h - (c_hpw + c_hbp + 2) : 0;
         automatic int xy  = (xde != 0) ? m_v - (c_vpw + 1 + c_vbp) : 0;
         automatic int xfs = (xce != 0 && xde != 0 && xx == 0 && xy == 0) ? 1 : 0;
         chk(int'(pix_ce) == xce, "R1 R2 pix_ce", int'(pix_ce), xce);
         chk(int'(hsync) == xhs, "R3 R5 R9 hsync", int'(hsync), xhs);
         chk(int'(vsync) == xvs, "R4 R5 vsync", int'(vsync), xvs);
         chk(int'(de) == xde, "R6 R9 de", int'(de), xde);
         chk(int'(px_x) == xx, "R6 px_x", int'(px_x), xx);
         chk(int'(px_y) == xy, "R6 px_y", int'(px_y), xy);
         chk(int'(frame_start) == xfs, "R7 frame_start", int'(frame_start), xfs);
         chk(int'(busy) == m_run, "R8 busy", int'(busy), m_run);
      end
   end

   // independent strobe count per frame
   int fs_count = 0;
   always @(negedge clk) if (rst_n && frame_start) fs_count++;

   task automatic wait_idle(input string req);
      int n = 0;
      while (busy && n < 5000) begin @(negedge clk); n++; end
      chk(!busy, req, int'(busy), 0);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin : watchdog
      repeat (WDOG) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
      finish_run();
   end

   initial begin : stim
      // config A: bypass, 9 x 6 raster
      cfg_bypass = 1; cfg_clkdiv = 0;
      cfg_hpw = 1; cfg_hbp = 1; cfg_hact = 3; cfg_hfp = 0;
      cfg_vpw = 0; cfg_vbp = 1; cfg_vact = 2; cfg_vfp = 1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset / idle state
      chk(busy == 0, "R8 reset busy", int'(busy), 0);
      chk(de == 0 && pix_ce == 0 && frame_start == 0, "R8 reset quiet", int'(de | pix_ce), 0);
      chk(hsync == 0 && vsync == 0, "R5 reset sync level", int'(hsync | vsync), 0);
      cmp_on = 1'b1;

      pwr_en = 1'b1;
      @(negedge clk);
      chk(busy == 1, "R8 start", int'(busy), 1);
      fs_count = 0;
      repeat (54 * 3) @(negedge clk);
      // R7: three frames give three strobes
      chk(fs_count == 3, "R7 strobe count", fs_count, 3);

      // mid-frame change: config B with divider and inversion (R9)
      repeat (20) @(negedge clk);
      cfg_bypass = 0; cfg_clkdiv = 1; cfg_hs_inv = 1; cfg_vs_inv = 1; cfg_hact = 5;
      @(negedge clk);
      chk(hsync == 0 || hsync == 1, "R9 hold", 0, 0);
      repeat (264 * 2) @(negedge clk);

      // power down mid-frame (R8)
      repeat (37) @(negedge clk);
      pwr_en = 1'b0;
      @(negedge clk);
      chk(busy == 1, "R8 drain", int'(busy), 1);
      wait_idle("R8 stop at frame end");
      @(negedge clk);
      chk(hsync == 1 && vsync == 1, "R5 R8 idle inverted level", int'(hsync & vsync), 1);

      // config C: divide by 2, zero vertical porches (R4)
      cfg_clkdiv = 0; cfg_hs_inv = 0; cfg_vs_inv = 1;
      cfg_hpw = 0; cfg_hbp = 2; cfg_hact = 4; cfg_hfp = 1;
      cfg_vpw = 1; cfg_vbp = 0; cfg_vact = 3; cfg_vfp = 0;
      @(negedge clk);
      pwr_en = 1'b1;
      repeat (400) @(negedge clk);
      pwr_en = 1'b0;
      wait_idle("R8 second stop");
      repeat (5) @(negedge clk);
      chk(de == 0 && pix_ce == 0, "R8 idle quiet", int'(de | pix_ce), 0);
      chk(vsync == 1 && hsync == 0, "R5 idle levels", int'(vsync), 1);
      cmp_on = 1'b0;
      finish_run();
   end
endmodule